// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block takes CPU byte writes into one of two reserved 32 KiB address windows and turns them into SDRAM start-up commands for two chip-select areas. Area 0 is decoded at `0xFF900000` and area 1 at `0xFF940000`. No write data is taken. The command comes from the control input `mode_sel` and from the address alone. With `mode_sel` low, a write issues a precharge-all to the area that was hit. With `mode_sel` high, the write issues a mode-register set, and the window offset shifted right by two goes onto the SDRAM address lines as the mode word.

The block counts out a power-up idle time, set as clock frequency in MHz times the idle time in microseconds. Until that time has passed it issues no command. It also holds each area to a fixed order: precharge-all first, then at least `REF_MIN` auto-refresh cycles, then mode-register set. Auto-refresh commands come from an external refresh-request input. A refresh is sent to both areas at once, and it counts only for areas that have been precharged. Any window write that breaks these rules is dropped and sets a sticky error flag. Each area raises a ready output when its mode-register set goes out.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, no command is issued for IDLE = CLK_MHZ*IDLE_US clock edges. During that time a window write is rejected and sets `seq_err`, and a refresh request is dropped and never issued later. A write sampled on edge IDLE is rejected. A write sampled on edge IDLE+1 is accepted.
- R2: A write whose address bits [31:15] match neither window issues no command and sets no error, and it adds nothing to any refresh count.
- R3: A window write is accepted only if it is byte-sized (`bus_size` = 2'b00) and its offset has bits [1:0] = 0. Any other window write is rejected and sets `seq_err`.
- R4: An accepted write with `mode_sel`=0 drives precharge-all in the cycle after the sampling edge: RAS#=0, CAS#=1, WE#=1'b0, `sd_addr` bit 10 = 1, and only the target area's `sd_cs_n` bit low.
- R5: A refresh request issues auto-refresh (RAS#=0, CAS#=0, WE#=1) with both `sd_cs_n` bits low. If it arrives together with a window write, it is held and issued in the following cycle.
- R6: An accepted write with `mode_sel`=1 drives mode-register set (RAS#=CAS#=WE#=0) on the target chip select, with `sd_addr` = offset>>2. Offsets 0x48/0x88/0xC8 give burst length 4 (mode bits [2:0]=2) with CAS latency 1/2/3 in bits [6:4]. Offsets 0x4C/0x8C/0xCC give burst length 8 (bits [2:0]=3) with the same latencies.
- R7: A mode-set write to an area that has not been precharged, or that has fewer than REF_MIN refreshes since its precharge-all, issues no command, sets `seq_err`, and leaves that area's ready output low.
- R8: `area_ready[i]` rises in the same cycle as the mode-register set on area i, and a later precharge-all to that area clears it.
- R9: `seq_err` stays set until reset.
- R10: During and right after reset, all chip selects are high, the command pins read no-operation, `area_ready` is 0, and `seq_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_addr | input | 32 | CPU write address |
| bus_size | input | 2 | Access size, 2'b00 = byte |
| mode_sel | input | 1 | 0: precharge-all, 1: mode-register set |
| refresh_req | input | 1 | Auto-refresh request from the refresh timer |
| sd_cs_n | output | N_AREA | Chip select per area, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_AW | SDRAM address lines |
| area_ready | output | N_AREA | Area has completed its mode-register set |
| seq_err | output | 1 | Sticky rejected-write flag |

## Verification
Every command, ready change and error change comes from one register stage, so each appears in the cycle after the edge that sampled the write or request. The bench drives inputs on the falling edge and samples on the next falling edge, which is exactly one edge later. The only exception is a refresh deferred by a coincident write: it is sampled one further falling edge on. The idle boundary is probed at edges IDLE and IDLE+1 by counting falling edges from the release of reset. The sweep runs a full sequence for each area and each of the six mode offsets, and it computes the expected mode word as offset/4.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  localparam int N_AREA = 2;

  typedef enum logic [1:0] {AR_UNINIT, AR_PRECH, AR_REFRESH, AR_READY} area_st_e;
  typedef enum logic [1:0] {C_NOP, C_PALL, C_REF, C_MRS} cmd_e;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmd_pins(cmd_e c);
    case (c)
      C_PALL:  return 3'b010;
      C_REF:   return 3'b001;
      C_MRS:   return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic int unsigned idle_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  function automatic logic [31:0] area_base(int unsigned a);
    return 32'hFF90_0000 + (32'(a) * 32'h0004_0000);
  endfunction
endpackage

// File: rtl/sdram_idle_timer.sv
module sdram_idle_timer #(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned IDLE_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic idle_done
);
  import sdram_init_pkg::*;
  localparam int unsigned IDLE = idle_cycles(CLK_MHZ, IDLE_US);
  localparam int CW = $clog2(IDLE + 1) > 0 ? $clog2(IDLE + 1) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(IDLE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign idle_done = (cnt == LIMIT);
endmodule

// File: rtl/sdram_win_decode.sv
module sdram_win_decode #(
  parameter int ROW_AW = 13
) (
  input  logic [31:0]                        addr,
  output logic [sdram_init_pkg::N_AREA-1:0]  hit_vec,
  output logic                               aligned,
  output logic [ROW_AW-1:0]                  mode_val
);
  import sdram_init_pkg::*;
  localparam int WB = ROW_AW + 2;

  for (genvar a = 0; a < N_AREA; a++) begin : g_win
    localparam logic [31:0] BASE = area_base(a);
    assign hit_vec[a] = (addr[31:WB] == BASE[31:WB]);
  end

  assign aligned  = (addr[1:0] == 2'b00);
  assign mode_val = addr[WB-1:2];
endmodule

// File: rtl/sdram_area_fsm.sv
module sdram_area_fsm #(
  parameter int REF_MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pall_go,
  input  logic mrs_go,
  input  logic ref_go,
  output logic ref_ok,
  output logic ready
);
  import sdram_init_pkg::*;
  localparam int CW = $clog2(REF_MIN + 1);
  localparam logic [CW-1:0] TARGET = CW'(REF_MIN);

  area_st_e      st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= AR_UNINIT;
      cnt <= '0;
    end else if (pall_go) begin
      st  <= AR_PRECH;
      cnt <= '0;
    end else if (mrs_go) begin
      st  <= AR_READY;
    end else if (ref_go && (st == AR_PRECH || st == AR_REFRESH)) begin
      st <= AR_REFRESH;
      if (cnt != TARGET) cnt <= cnt + 1'b1;
    end
  end

  assign ref_ok = (st == AR_REFRESH) && (cnt == TARGET);
  assign ready  = (st == AR_READY);
endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg #(
  parameter int ROW_AW = 13
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  sdram_init_pkg::cmd_e               cmd,
  input  logic [sdram_init_pkg::N_AREA-1:0]  cs_sel,
  input  logic [ROW_AW-1:0]                  addr_in,
  output logic [sdram_init_pkg::N_AREA-1:0]  cs_n,
  output logic                               ras_n,
  output logic                               cas_n,
  output logic                               we_n,
  output logic [ROW_AW-1:0]                  addr
);
  import sdram_init_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n                 <= '1;
      {ras_n, cas_n, we_n} <= cmd_pins(C_NOP);
      addr                 <= '0;
    end else begin
      cs_n                 <= ~cs_sel;
      {ras_n, cas_n, we_n} <= cmd_pins(cmd);
      addr                 <= addr_in;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int          ROW_AW  = 13,
  parameter int          REF_MIN = 8,
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned IDLE_US = 200
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_wr,
  input  logic [31:0]                        bus_addr,
  input  logic [1:0]                         bus_size,
  input  logic                               mode_sel,
  input  logic                               refresh_req,
  output logic [sdram_init_pkg::N_AREA-1:0]  sd_cs_n,
  output logic                               sd_ras_n,
  output logic                               sd_cas_n,
  output logic                               sd_we_n,
  output logic [ROW_AW-1:0]                  sd_addr,
  output logic [sdram_init_pkg::N_AREA-1:0]  area_ready,
  output logic                               seq_err
);
  import sdram_init_pkg::*;
  localparam logic [ROW_AW-1:0] PALL_ADDR = ROW_AW'(1) << 10;

  logic              idle_done;
  logic [N_AREA-1:0] hit_vec, ref_ok_vec, pall_vec, mrs_vec;
  logic              aligned, wr_go, form_ok, sel_ref_ok;
  logic              accept_pall, accept_mrs, reject;
  logic              ref_pend, ref_want, ref_fire;
  logic [ROW_AW-1:0] mode_val, addr_nxt;
  logic [N_AREA-1:0] cs_nxt;
  cmd_e              cmd_nxt;

  sdram_idle_timer #(.CLK_MHZ(CLK_MHZ), .IDLE_US(IDLE_US)) u_idle (
    .clk(clk), .rst_n(rst_n), .idle_done(idle_done));

  sdram_win_decode #(.ROW_AW(ROW_AW)) u_dec (
    .addr(bus_addr), .hit_vec(hit_vec), .aligned(aligned), .mode_val(mode_val));

  assign wr_go       = bus_wr && (|hit_vec);
  assign form_ok     = (bus_size == 2'b00) && aligned;
  assign sel_ref_ok  = |(hit_vec & ref_ok_vec);
  assign accept_pall = wr_go && form_ok && idle_done && !mode_sel;
  assign accept_mrs  = wr_go && form_ok && idle_done && mode_sel && sel_ref_ok;
  assign reject      = wr_go && !(accept_pall || accept_mrs);
  assign pall_vec    = hit_vec & {N_AREA{accept_pall}};
  assign mrs_vec     = hit_vec & {N_AREA{accept_mrs}};

  assign ref_want = refresh_req || ref_pend;
  assign ref_fire = ref_want && idle_done && !wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pend <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      ref_pend <= ref_want && idle_done && !ref_fire;
      if (reject) seq_err <= 1'b1;
    end
  end

  for (genvar a = 0; a < N_AREA; a++) begin : g_area
    sdram_area_fsm #(.REF_MIN(REF_MIN)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .pall_go(pall_vec[a]), .mrs_go(mrs_vec[a]), .ref_go(ref_fire),
      .ref_ok(ref_ok_vec[a]), .ready(area_ready[a]));
  end

  always_comb begin
    cmd_nxt  = C_NOP;
    cs_nxt   = '0;
    addr_nxt = '0;
    if (accept_pall) begin
      cmd_nxt  = C_PALL;
      cs_nxt   = hit_vec;
      addr_nxt = PALL_ADDR;
    end else if (accept_mrs) begin
      cmd_nxt  = C_MRS;
      cs_nxt   = hit_vec;
      addr_nxt = mode_val;
    end else if (ref_fire) begin
      cmd_nxt  = C_REF;
      cs_nxt   = '1;
    end
  end

  sdram_cmd_reg #(.ROW_AW(ROW_AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_nxt), .cs_sel(cs_nxt), .addr_in(addr_nxt),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n), .addr(sd_addr));
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               idle_done,
  input logic                               ref_fire,
  input logic [sdram_init_pkg::N_AREA-1:0]  sd_cs_n,
  input logic                               sd_ras_n,
  input logic                               sd_cas_n,
  input logic                               sd_we_n,
  input logic [sdram_init_pkg::N_AREA-1:0]  area_ready,
  input logic                               seq_err
);
  import sdram_init_pkg::*;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_done |=> (sd_cs_n == '1));

  // R5
  ref_all_areas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> (sd_cs_n == '0 && !sd_ras_n && !sd_cas_n && sd_we_n));

  // R4
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_ras_n && !sd_we_n) |-> ($countones(~sd_cs_n) == 1));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  for (genvar a = 0; a < N_AREA; a++) begin : g_rdy
    // R8
    ready_with_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(area_ready[a]) |-> (!sd_cs_n[a] && !sd_ras_n && !sd_cas_n && !sd_we_n));
  end
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (.*);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
  localparam int B_AW = 13, B_REF = 8, B_MHZ = 1, B_US = 20;
  localparam int IDLE_CYC = B_MHZ * B_US;
  localparam logic [31:0] BASE0 = 32'hFF90_0000, BASE1 = 32'hFF94_0000;
  localparam logic [2:0] P_NOP = 3'b111, P_PALL = 3'b010, P_REF = 3'b001, P_MRS = 3'b000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, mode_sel = 1'b0, refresh_req = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0] bus_size = 2'b00;
  logic [1:0] sd_cs_n, area_ready;
  logic sd_ras_n, sd_cas_n, sd_we_n, seq_err;
  logic [B_AW-1:0] sd_addr;
  logic [2:0] pins;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign pins = {sd_ras_n, sd_cas_n, sd_we_n};
  always #10 clk = ~clk;

  sdram_init_seq #(.ROW_AW(B_AW), .REF_MIN(B_REF), .CLK_MHZ(B_MHZ), .IDLE_US(B_US)) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .mode_sel(mode_sel), .refresh_req(refresh_req), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .area_ready(area_ready),
    .seq_err(seq_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; refresh_req = 1'b0; mode_sel = 1'b0;
    bus_addr = '0; bus_size = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    repeat (IDLE_CYC) @(negedge clk);
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [1:0] sz, input logic ms);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; mode_sel = ms;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic refresh_pulse();
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
  endtask

  task automatic pall_ok(input int a, input string tag);
    bus_write(a == 0 ? BASE0 : BASE1, 2'b00, 1'b0);
    chk({tag, " pins"}, 32'(pins), 32'(P_PALL));
    chk({tag, " cs"}, 32'(sd_cs_n), a == 0 ? 32'h2 : 32'h1);
    chk({tag, " a10"}, 32'(sd_addr[10]), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    @(negedge clk);
    chk("R10 cs", 32'(sd_cs_n), 32'h3);
    chk("R10 pins", 32'(pins), 32'(P_NOP));
    chk("R10 ready", 32'(area_ready), 32'h0);
    chk("R10 err", 32'(seq_err), 32'h0);
    rst_n = 1'b1;

    // R1 refresh during idle is dropped, never issued later
    do_reset();
    refresh_pulse();
    chk("R1 ref in idle pins", 32'(pins), 32'(P_NOP));
    wait_idle();
    chk("R1 dropped ref cs", 32'(sd_cs_n), 32'h3);

    // R1 boundary: write sampled on edge IDLE is rejected
    do_reset();
    repeat (IDLE_CYC - 1) @(negedge clk);
    bus_write(BASE0, 2'b00, 1'b0);
    chk("R1 early pins", 32'(pins), 32'(P_NOP));
    chk("R1 early err", 32'(seq_err), 32'h1);

    // R1 boundary: write sampled on edge IDLE+1 is accepted
    do_reset();
    wait_idle();
    pall_ok(0, "R1 R4 first legal");
    chk("R1 no err", 32'(seq_err), 32'h0);

    // R3 non-byte size
    do_reset(); wait_idle();
    bus_write(BASE1, 2'b10, 1'b0);
    chk("R3 word pins", 32'(pins), 32'(P_NOP));
    chk("R3 word err", 32'(seq_err), 32'h1);
    // R3 misaligned offset
    do_reset(); wait_idle();
    bus_write(BASE0 + 32'h49, 2'b00, 1'b0);
    chk("R3 misalign pins", 32'(pins), 32'(P_NOP));
    chk("R3 misalign err", 32'(seq_err), 32'h1);

    // R7 mode set before precharge-all
    do_reset(); wait_idle();
    bus_write(BASE1 + 32'h88, 2'b00, 1'b1);
    chk("R7 no pall pins", 32'(pins), 32'(P_NOP));
    chk("R7 no pall err", 32'(seq_err), 32'h1);
    chk("R7 no pall ready", 32'(area_ready), 32'h0);

    // R5 coincident refresh deferred; R7 short count; R9 sticky
    do_reset(); wait_idle();
    refresh_req = 1'b1;
    bus_write(BASE1, 2'b00, 1'b0);
    refresh_req = 1'b0;
    chk("R5 coincide first pins", 32'(pins), 32'(P_PALL));
    chk("R5 coincide first cs", 32'(sd_cs_n), 32'h1);
    @(negedge clk);
    chk("R5 deferred pins", 32'(pins), 32'(P_REF));
    chk("R5 deferred cs", 32'(sd_cs_n), 32'h0);
    for (int i = 0; i < B_REF - 2; i++) refresh_pulse();
    // R2 outside window does not count or err
    bus_write(32'hFF98_0048, 2'b00, 1'b1);
    chk("R2 outside pins", 32'(pins), 32'(P_NOP));
    chk("R2 outside err", 32'(seq_err), 32'h0);
    bus_write(BASE1 + 32'h48, 2'b00, 1'b1);
    chk("R7 short pins", 32'(pins), 32'(P_NOP));
    chk("R7 short err", 32'(seq_err), 32'h1);
    chk("R7 short ready", 32'(area_ready), 32'h0);
    refresh_pulse();
    bus_write(BASE1 + 32'h48, 2'b00, 1'b1);
    chk("R6 after full count pins", 32'(pins), 32'(P_MRS));
    chk("R8 ready area1", 32'(area_ready), 32'h2);
    chk("R9 err kept", 32'(seq_err), 32'h1);

    // R6 sweep: both areas, both burst lengths, CAS latency 1..3
    for (int a = 0; a < 2; a++) begin
      for (int bl = 0; bl < 2; bl++) begin
        for (int cl = 1; cl <= 3; cl++) begin
          logic [31:0] off;
          off = 32'(cl) * 32'h40 + 32'h08 + 32'(bl) * 32'h4;
          do_reset(); wait_idle();
          pall_ok(a, "R4 sweep pall");
          for (int r = 0; r < B_REF; r++) begin
            refresh_pulse();
            chk("R5 sweep ref", 32'({pins, sd_cs_n}), 32'({P_REF, 2'b00}));
          end
          bus_write((a == 0 ? BASE0 : BASE1) + off, 2'b00, 1'b1);
          chk("R6 mrs pins", 32'(pins), 32'(P_MRS));
          chk("R6 mrs cs", 32'(sd_cs_n), a == 0 ? 32'h2 : 32'h1);
          chk("R6 mode word", 32'(sd_addr), off >> 2);
          chk("R6 cas lat", 32'(sd_addr[6:4]), 32'(cl));
          chk("R6 burst code", 32'(sd_addr[2:0]), 32'(2 + bl));
          chk("R8 ready", 32'(area_ready), a == 0 ? 32'h1 : 32'h2);
          chk("R9 clean", 32'(seq_err), 32'h0);
        end
      end
      // R8 re-precharge clears ready
      pall_ok(a, "R8 re-pall");
      chk("R8 ready cleared", 32'(area_ready), 32'h0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule